// File: doc/BRIEF.md
# Memory Bank Option Controller

The block sits between a bus master and a set of external memory banks. Every bank carries a base word and an option word. The base word holds an upper-address tag and a valid flag. The option word holds four things: an address mask over the same upper bits, a flag that suppresses the data-buffer strobe, a flag that forbids bursts, and a two-bit code that sets how many idle cycles must follow a read. Software fills these words through a one-cycle write port.

For each request the controller compares the address against all valid banks at once. The lowest-numbered bank that matches wins, and its select line is raised for the whole access. Each access is started on a memory-side request/acknowledge pair. A burst bound for a bank that forbids bursts is replayed as a run of single beats, and each beat waits for its own acknowledge. After the last beat of a read, the controller holds off new requests for the bank's programmed gap. An address that no bank claims is accepted and dropped, and an error pulse is raised.

Top module: `bank_option_ctrl`

## Requirements
- R1: After reset every bank is invalid and all option fields are zero. `req_ready` is high, and `busy`, `err`, `mem_req`, `buf_ctl` and `bank_sel` are all low.
- R2: The tag is address bits 31:15, and the mask covers the same bits. A set mask bit demands that the address bit equal the base bit, and a clear mask bit drops that bit from the compare. Any mask pattern is legal, including non-contiguous ones.
- R3: Only banks whose valid flag (base word bit 0) is set take part in the compare. When several banks match, the lowest index wins.
- R4: A request that no bank matches is accepted. `err` is high for exactly the cycle after acceptance. No bank select and no `mem_req` are raised for it.
- R5: `mem_req` rises in the cycle after acceptance. While `mem_req` is high, `bank_sel` is one-hot on the winning bank and stays stable.
- R6: `buf_ctl` follows `mem_req` unless the bank's buffer-strobe disable flag (option bit 12) is set. With the flag set, `buf_ctl` stays low.
- R7: A burst to a bank whose burst-inhibit flag (option bit 8) is clear runs as one handshake with `mem_burst` high.
- R8: A burst to a bank with burst inhibit set runs as four handshakes with `mem_burst` low. The address advances by 8 bytes after each acknowledge.
- R9: After the last acknowledge of a read, `busy` is high and `req_ready` is low for N cycles. N is set by the hold code in option bits 2:1: code 0 gives 0 cycles, code 1 gives 1, code 2 gives 4 and code 3 gives 8.
- R10: A write never starts a gap. `req_ready` is high again in the cycle after its last acknowledge.
- R11: A configuration write with `cfg_opt` low loads the base word, and with `cfg_opt` high it loads the option word (mask in bits 31:15), for the bank at `cfg_bank`. The new value applies from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_bank | input | 4 | Bank index to write |
| cfg_opt | input | 1 | 0 selects the base word, 1 selects the option word |
| cfg_wdata | input | 32 | Configuration data |
| req_valid | input | 1 | Master request valid |
| req_ready | output | 1 | Request accepted this cycle when high with `req_valid` |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_burst | input | 1 | Request is a four-beat burst |
| mem_req | output | 1 | Memory-side beat request |
| mem_ack | input | 1 | Memory-side acknowledge |
| mem_addr | output | 32 | Address of the current beat |
| mem_we | output | 1 | Direction of the current beat |
| mem_burst | output | 1 | Current handshake covers a whole burst |
| bank_sel | output | 12 | One-hot bank select |
| buf_ctl | output | 1 | Data buffer control strobe |
| busy | output | 1 | Post-read idle gap in progress |
| err | output | 1 | One-cycle pulse for an unmatched address |

## Verification
The bench aims at overlapping banks, where a priority inverted toward the highest index or a decoder that lets an invalid bank through would raise the wrong select. It uses a non-contiguous mask with an address bit the mask ignores, so that a decoder treating the mask as a plain prefix would miss the region. It measures the idle gap for each hold code against 0, 1, 4 and 8 and checks that writes leave no gap; an off-by-one counter or a wrong code table shows as a wrong gap length. Split bursts must show four acknowledges with addresses stepping by 8, while whole bursts must show one handshake with the burst flag high.

// File: rtl/bank_opt_pkg.sv
package bank_opt_pkg;

  localparam int ADDR_W   = 32;
  localparam int MASK_W   = 17;
  localparam int TAG_LSB  = ADDR_W - MASK_W;
  localparam int GAP_W    = 4;

  // option word field positions
  localparam int OPT_BUFDIS_BIT = 12;
  localparam int OPT_NOBURST_BIT = 8;
  localparam int OPT_HOLD_LSB   = 1;
  // base word field positions
  localparam int BASE_VALID_BIT = 0;

  typedef enum logic {S_IDLE = 1'b0, S_ACC = 1'b1} seq_state_t;

  typedef struct packed {
    logic              valid;
    logic [MASK_W-1:0] base;
    logic [MASK_W-1:0] mask;
    logic              buf_dis;
    logic              no_burst;
    logic [1:0]        hold;
  } bank_cfg_t;

  // idle cycles after a read for each hold code
  function automatic logic [GAP_W-1:0] hold_gap(input logic [1:0] code);
    logic [GAP_W-1:0] n;
    unique case (code)
      2'd0: n = GAP_W'(0);
      2'd1: n = GAP_W'(1);
      2'd2: n = GAP_W'(4);
      default: n = GAP_W'(8);
    endcase
    return n;
  endfunction

  // a bank claims an address when every unmasked tag bit agrees
  function automatic logic tag_hit(input logic [ADDR_W-1:0] addr, input bank_cfg_t c);
    logic [MASK_W-1:0] diff;
    diff = (addr[ADDR_W-1:TAG_LSB] ^ c.base) & c.mask;
    return c.valid && (diff == '0);
  endfunction

endpackage

// File: rtl/bank_opt_regs.sv
module bank_opt_regs import bank_opt_pkg::*; #(
  parameter int NUM_BANKS  = 12,
  parameter int BANK_IDX_W = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [BANK_IDX_W-1:0] cfg_bank,
  input  logic                  cfg_opt,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  output bank_cfg_t [NUM_BANKS-1:0] cfg_o
);

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
    logic hit_wr;
    assign hit_wr = cfg_we && (cfg_bank == BANK_IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_o[i] <= '0;
      end else if (hit_wr) begin
        if (!cfg_opt) begin
          cfg_o[i].valid <= cfg_wdata[BASE_VALID_BIT];
          cfg_o[i].base  <= cfg_wdata[ADDR_W-1:TAG_LSB];
        end else begin
          cfg_o[i].mask     <= cfg_wdata[ADDR_W-1:TAG_LSB];
          cfg_o[i].buf_dis  <= cfg_wdata[OPT_BUFDIS_BIT];
          cfg_o[i].no_burst <= cfg_wdata[OPT_NOBURST_BIT];
          cfg_o[i].hold     <= cfg_wdata[OPT_HOLD_LSB+1:OPT_HOLD_LSB];
        end
      end
    end
  end

endmodule

// File: rtl/bank_opt_decode.sv
module bank_opt_decode import bank_opt_pkg::*; #(
  parameter int NUM_BANKS  = 12,
  parameter int BANK_IDX_W = $clog2(NUM_BANKS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  bank_cfg_t [NUM_BANKS-1:0] cfg_i,
  output logic                      hit_any,
  output logic [BANK_IDX_W-1:0]     hit_idx
);

  logic [NUM_BANKS-1:0] hit_vec;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
    assign hit_vec[i] = tag_hit(addr, cfg_i[i]);
  end

  // scan downward so the lowest matching index is the last one written
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BANKS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = BANK_IDX_W'(i);
    end
  end

  assign hit_any = |hit_vec;

  AST_DEC_WINNER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> hit_vec[hit_idx]);  // R3
  AST_DEC_NONE_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> ((hit_vec & ((NUM_BANKS'(1) << hit_idx) - NUM_BANKS'(1))) == '0));  // R3

endmodule

// File: rtl/bank_opt_seq.sv
module bank_opt_seq import bank_opt_pkg::*; #(
  parameter int NUM_BANKS   = 12,
  parameter int BANK_IDX_W  = $clog2(NUM_BANKS),
  parameter int BURST_BEATS = 4,
  parameter int BEAT_BYTES  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_write,
  input  logic                      req_burst,
  input  logic                      hit_any,
  input  logic [BANK_IDX_W-1:0]     hit_idx,
  input  bank_cfg_t [NUM_BANKS-1:0] cfg_i,
  output logic                      mem_req,
  input  logic                      mem_ack,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic                      mem_we,
  output logic                      mem_burst,
  output logic [NUM_BANKS-1:0]      bank_sel,
  output logic                      buf_ctl,
  output logic                      busy,
  output logic                      err
);

  localparam int BEAT_CNT_W = $clog2(BURST_BEATS + 1);

  seq_state_t            st_q;
  logic [BANK_IDX_W-1:0] idx_q;
  logic [ADDR_W-1:0]     addr_q;
  logic                  we_q;
  logic                  burst_q;
  logic [BEAT_CNT_W-1:0] beats_q;
  logic [GAP_W-1:0]      gap_q;
  logic                  err_q;

  bank_cfg_t hit_cfg, cur_cfg;

  // named events for the checks
  logic in_access, last_beat, accept_evt, finish_evt, step_evt, miss_evt;

  always_comb begin
    hit_cfg = '0;
    cur_cfg = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (hit_idx == BANK_IDX_W'(i)) hit_cfg = cfg_i[i];
      if (idx_q == BANK_IDX_W'(i))   cur_cfg = cfg_i[i];
    end
  end

  assign in_access  = (st_q == S_ACC);
  assign last_beat  = (beats_q == BEAT_CNT_W'(1));
  assign req_ready  = (st_q == S_IDLE) && (gap_q == '0);
  assign accept_evt = req_valid && req_ready;
  assign miss_evt   = accept_evt && !hit_any;
  assign finish_evt = in_access && mem_ack && last_beat;
  assign step_evt   = in_access && mem_ack && !last_beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      burst_q <= 1'b0;
      beats_q <= '0;
      gap_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= miss_evt;
      unique case (st_q)
        S_IDLE: begin
          if (gap_q != '0) begin
            gap_q <= gap_q - GAP_W'(1);
          end else if (accept_evt && hit_any) begin
            st_q    <= S_ACC;
            idx_q   <= hit_idx;
            addr_q  <= req_addr;
            we_q    <= req_write;
            burst_q <= req_burst && !hit_cfg.no_burst;
            beats_q <= (req_burst && hit_cfg.no_burst) ? BEAT_CNT_W'(BURST_BEATS)
                                                        : BEAT_CNT_W'(1);
          end
        end
        S_ACC: begin
          if (finish_evt) begin
            st_q  <= S_IDLE;
            gap_q <= we_q ? '0 : hold_gap(cur_cfg.hold);
          end else if (step_evt) begin
            beats_q <= beats_q - BEAT_CNT_W'(1);
            addr_q  <= addr_q + ADDR_W'(BEAT_BYTES);
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_sel
    assign bank_sel[i] = in_access && (idx_q == BANK_IDX_W'(i));
  end

  assign mem_req   = in_access;
  assign mem_addr  = in_access ? addr_q : '0;
  assign mem_we    = in_access && we_q;
  assign mem_burst = in_access && burst_q;
  assign buf_ctl   = in_access && !cur_cfg.buf_dis;
  assign busy      = (gap_q != '0);
  assign err       = err_q;

  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_access && !finish_evt) |=> $stable(bank_sel));  // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (mem_addr == $past(mem_addr) + ADDR_W'(BEAT_BYTES)));  // R8
  AST_WRITE_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (finish_evt && mem_we) |=> (!busy && req_ready));  // R10
  AST_GAP_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (gap_q == $past(gap_q) - GAP_W'(1)));  // R9
  AST_MISS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> (err && !mem_req));  // R4

endmodule

// File: rtl/bank_option_ctrl.sv
module bank_option_ctrl import bank_opt_pkg::*; #(
  parameter int NUM_BANKS   = 12,
  parameter int BANK_IDX_W  = $clog2(NUM_BANKS),
  parameter int BURST_BEATS = 4,
  parameter int BEAT_BYTES  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [BANK_IDX_W-1:0] cfg_bank,
  input  logic                  cfg_opt,
  input  logic [ADDR_W-1:0]     cfg_wdata,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  req_write,
  input  logic                  req_burst,
  output logic                  mem_req,
  input  logic                  mem_ack,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic                  mem_burst,
  output logic [NUM_BANKS-1:0]  bank_sel,
  output logic                  buf_ctl,
  output logic                  busy,
  output logic                  err
);

  bank_cfg_t [NUM_BANKS-1:0] cfg;
  logic                      hit_any;
  logic [BANK_IDX_W-1:0]     hit_idx;

  bank_opt_regs #(.NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_opt(cfg_opt), .cfg_wdata(cfg_wdata), .cfg_o(cfg)
  );

  bank_opt_decode #(.NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .addr(req_addr), .cfg_i(cfg),
    .hit_any(hit_any), .hit_idx(hit_idx)
  );

  bank_opt_seq #(
    .NUM_BANKS(NUM_BANKS), .BANK_IDX_W(BANK_IDX_W),
    .BURST_BEATS(BURST_BEATS), .BEAT_BYTES(BEAT_BYTES)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .hit_any(hit_any), .hit_idx(hit_idx), .cfg_i(cfg),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_burst(mem_burst), .bank_sel(bank_sel), .buf_ctl(buf_ctl),
    .busy(busy), .err(err)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bank_sel) && (mem_req == (bank_sel != '0)));  // R5
  AST_ERR_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (bank_sel == '0));  // R4
  AST_BUFCTL_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_ctl |-> mem_req);  // R6
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);  // R9

endmodule

// File: tb/bank_option_ctrl_test.sv
`timescale 1ns/1ps
module bank_option_ctrl_test;

  localparam int NB = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_bank = '0;
  logic        cfg_opt = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        req_burst = 1'b0;
  logic        mem_req;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_addr;
  logic        mem_we;
  logic        mem_burst;
  logic [NB-1:0] bank_sel;
  logic        buf_ctl;
  logic        busy;
  logic        err;

  always #2.5 clk = ~clk;

  bank_option_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_opt(cfg_opt),
    .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_burst(req_burst),
    .mem_req(mem_req), .mem_ack(mem_ack), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_burst(mem_burst), .bank_sel(bank_sel), .buf_ctl(buf_ctl),
    .busy(busy), .err(err)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- reference model ----------------
  int m_valid[NB], m_base[NB], m_mask[NB], m_bufdis[NB], m_nob[NB], m_hold[NB];
  int gap_table[4] = '{0, 1, 4, 8};
  int m_st, m_bank, m_beats, m_gap, m_we, m_burst, m_err, m_hit, m_errn;
  longint m_addr;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) begin
        m_valid[i] = 0; m_base[i] = 0; m_mask[i] = 0;
        m_bufdis[i] = 0; m_nob[i] = 0; m_hold[i] = 0;
      end
      m_st = 0; m_bank = 0; m_beats = 0; m_gap = 0; m_we = 0;
      m_burst = 0; m_err = 0; m_addr = 0;
    end else begin
      m_errn = 0;
      if (m_st == 0) begin
        if (m_gap > 0) m_gap--;
        else if (req_valid) begin
          m_hit = -1;
          for (int i = 0; i < NB; i++)
            if (m_hit < 0 && m_valid[i] != 0 &&
                (((int'(req_addr >> 15)) ^ m_base[i]) & m_mask[i]) == 0) m_hit = i;
          if (m_hit < 0) m_errn = 1;
          else begin
            m_st = 1; m_bank = m_hit; m_addr = req_addr; m_we = req_write;
            m_burst = (req_burst && m_nob[m_hit] == 0);
            m_beats = (req_burst && m_nob[m_hit] != 0) ? 4 : 1;
          end
        end
      end else if (mem_ack) begin
        if (m_beats == 1) begin
          m_st = 0;
          m_gap = m_we ? 0 : gap_table[m_hold[m_bank]];
        end else begin
          m_beats--; m_addr = m_addr + 8;
        end
      end
      m_err = m_errn;
      if (cfg_we && cfg_bank < NB) begin
        if (!cfg_opt) begin
          m_valid[cfg_bank] = cfg_wdata[0];
          m_base[cfg_bank]  = int'(cfg_wdata >> 15);
        end else begin
          m_mask[cfg_bank]   = int'(cfg_wdata >> 15);
          m_bufdis[cfg_bank] = cfg_wdata[12];
          m_nob[cfg_bank]    = cfg_wdata[8];
          m_hold[cfg_bank]   = int'(cfg_wdata[2:1]);
        end
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [NB-1:0] e_sel;
      e_sel = (m_st == 1) ? (NB'(1) << m_bank) : '0;
      check(bank_sel == e_sel, "R5 bank_sel", bank_sel, e_sel);
      check(mem_req == (m_st == 1), "R5 mem_req", mem_req, m_st);
      check(buf_ctl == (m_st == 1 && m_bufdis[m_bank] == 0), "R6 buf_ctl", buf_ctl,
            (m_st == 1 && m_bufdis[m_bank] == 0));
      check(mem_burst == (m_st == 1 && m_burst != 0), "R7 mem_burst", mem_burst,
            (m_st == 1 && m_burst != 0));
      check(mem_addr == ((m_st == 1) ? 32'(m_addr) : 32'h0), "R8 mem_addr", mem_addr,
            (m_st == 1) ? m_addr : 0);
      check(mem_we == (m_st == 1 && m_we != 0), "R10 mem_we", mem_we, (m_st == 1 && m_we != 0));
      check(busy == (m_gap != 0), "R9 busy", busy, m_gap);
      check(req_ready == (m_st == 0 && m_gap == 0), "R9 req_ready", req_ready,
            (m_st == 0 && m_gap == 0));
      check(err == (m_err != 0), "R4 err", err, m_err);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_write(input int bank, input bit opt, input logic [31:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_bank = 4'(bank); cfg_opt = opt; cfg_wdata = data;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic [31:0] opt_word(input logic [16:0] mask, input bit bufdis,
                                           input bit nob, input logic [1:0] hold);
    return {mask, 15'b0} | (32'(bufdis) << 12) | (32'(nob) << 8) | (32'(hold) << 1);
  endfunction

  int r_hs, r_sel, r_gap;
  bit r_buf, r_burst, r_err;
  logic [31:0] r_addr[4];

  task automatic access(input logic [31:0] a, input bit we, input bit bu);
    bit tog;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = we; req_burst = bu;
    @(negedge clk);
    req_valid = 1'b0;
    r_hs = 0; r_sel = -1; r_gap = 0; r_buf = 0; r_burst = 0; r_err = err; tog = 1'b0;
    while (mem_req) begin
      if (r_sel < 0)
        for (int i = 0; i < NB; i++) if (bank_sel[i]) r_sel = i;
      r_buf |= buf_ctl;
      r_burst |= mem_burst;
      mem_ack = tog;
      if (tog) begin
        if (r_hs < 4) r_addr[r_hs] = mem_addr;
        r_hs++;
      end
      tog = ~tog;
      @(negedge clk);
    end
    mem_ack = 1'b0;
    while (busy) begin
      r_gap++;
      @(negedge clk);
    end
  endtask

  // ---------------- watchdog ----------------
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !finished) begin
      finished = 1'b1;
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- directed sequence ----------------
  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values at the ports
    check(req_ready == 1'b1 && busy == 1'b0 && err == 1'b0, "R1 idle flags",
          {req_ready, busy, err}, 3'b100);
    check(bank_sel == '0 && mem_req == 1'b0 && buf_ctl == 1'b0, "R1 no select",
          bank_sel, 0);
    rst_n = 1'b1;

    // R1/R4: no bank valid after reset, so any address misses
    access(32'h4000_0010, 1'b0, 1'b0);
    check(r_err == 1'b1 && r_sel == -1, "R4 miss after reset", r_err, 1);

    // R11: program banks through the write port
    cfg_write(2, 1'b0, 32'h4000_0000 | 32'h1);
    cfg_write(2, 1'b1, opt_word(17'h1FFFF, 1'b0, 1'b0, 2'd1));
    cfg_write(5, 1'b0, 32'h8000_0000 | 32'h1);
    cfg_write(5, 1'b1, opt_word(17'h14000, 1'b1, 1'b1, 2'd2));
    cfg_write(7, 1'b0, 32'h8000_0000 | 32'h1);
    cfg_write(7, 1'b1, opt_word(17'h10000, 1'b0, 1'b0, 2'd3));
    cfg_write(1, 1'b0, 32'h4000_0000);            // valid flag clear
    cfg_write(1, 1'b1, opt_word(17'h1FFFF, 1'b0, 1'b0, 2'd0));

    // R2/R3/R6/R9: exact match on bank 2, invalid bank 1 ignored, gap of one
    access(32'h4000_0010, 1'b0, 1'b0);
    check(r_sel == 2, "R3 invalid bank skipped", r_sel, 2);
    check(r_hs == 1 && r_buf == 1'b1, "R6 strobe on bank2", r_buf, 1);
    check(r_gap == 1, "R9 hold code 1", r_gap, 1);

    // R2/R4: one masked tag bit differs -> miss
    access(32'h4000_8000, 1'b0, 1'b0);
    check(r_err == 1'b1 && r_sel == -1, "R2 masked bit mismatch", r_err, 1);

    // R3/R6/R8/R9: overlap of banks 5 and 7, split burst, strobe off, gap 4
    access(32'h8000_0100, 1'b0, 1'b1);
    check(r_sel == 5, "R3 lowest index wins", r_sel, 5);
    check(r_hs == 4 && r_burst == 1'b0, "R8 four single beats", r_hs, 4);
    check(r_addr[3] == 32'h8000_0118 && r_addr[1] == 32'h8000_0108, "R8 address step",
          r_addr[3], 32'h8000_0118);
    check(r_buf == 1'b0, "R6 strobe suppressed", r_buf, 0);
    check(r_gap == 4, "R9 hold code 2", r_gap, 4);

    // R2: non-contiguous mask ignores bit 28
    access(32'h9000_0000, 1'b1, 1'b0);
    check(r_sel == 5, "R2 non-contiguous mask", r_sel, 5);
    check(r_gap == 0, "R10 write no gap", r_gap, 0);

    // R7/R9: bit 29 set excludes bank 5, bank 7 takes a whole burst, gap 8
    access(32'hA000_0000, 1'b0, 1'b1);
    check(r_sel == 7 && r_hs == 1 && r_burst == 1'b1, "R7 whole burst", r_hs, 1);
    check(r_gap == 8, "R9 hold code 3", r_gap, 8);

    // R10: write burst to a bank with a long hold code
    access(32'hA000_0040, 1'b1, 1'b1);
    check(r_gap == 0, "R10 write burst no gap", r_gap, 0);

    // R9/R11: reprogram hold code to 0
    cfg_write(2, 1'b1, opt_word(17'h1FFFF, 1'b0, 1'b0, 2'd0));
    access(32'h4000_0020, 1'b0, 1'b0);
    check(r_sel == 2 && r_gap == 0, "R9 hold code 0", r_gap, 0);

    // R3/R11: making bank 1 valid moves the winner to bank 1
    cfg_write(1, 1'b0, 32'h4000_0000 | 32'h1);
    access(32'h4000_0020, 1'b0, 1'b0);
    check(r_sel == 1, "R3 lower valid bank takes over", r_sel, 1);

    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule